// File: doc/BRIEF.md
# Two-Channel Bus Selector with Interrupt Combining

This block is a serial-bus target that decides which of two downstream bus channels is joined to the upstream bus. A host addresses it over SCL/SDA and writes one control byte. The byte's enable and select bits drive two channel-enable outputs, and those outputs steer external pass switches. At most one channel is ever enabled, and a new choice is applied only when the STOP that closes the write arrives. Reading the byte back returns the current selection together with the live state of the two downstream interrupt lines.

Each downstream channel has one active-low interrupt input. The block merges the two into a single active-low output that goes low when either input is low. Three strap inputs set the low bits of the bus address, so eight of these blocks can share one upstream bus. SCL and SDA are open-drain. The design models each line as a sampled input plus a pull-low enable, and it samples both lines on a system clock that runs at least 16 times faster than SCL.

Top module: `twin_chan_switch`

## Requirements
- R1: The block acknowledges, by pulling SDA low in the ninth clock, only the 7-bit address {4'b1110, strap[2], strap[1], strap[0]}. Any other address gets no acknowledge and leaves the selection unchanged.
- R2: The control byte decodes as follows. With bit 2 = 1 and bit 0 = 0, channel 0 is enabled (ch_en = 2'b01). With bit 2 = 1 and bit 0 = 1, channel 1 is enabled (ch_en = 2'b10). With bit 2 = 0, ch_en = 2'b00.
- R3: ch_en[0] and ch_en[1] are never both high.
- R4: While reset is held and after it is released, ch_en = 2'b00, SDA is released, the bus logic is idle and the control byte reads back as 8'h00.
- R5: irq_out_n is low exactly when irq0_n or irq1_n is low.
- R6: A read returns a byte with bit 2 = the committed enable, bit 0 = the committed select, bit 4 = NOT irq0_n, bit 5 = NOT irq1_n and all other bits 0. Each byte of a multi-byte read is loaded with the live state at the time it is loaded.
- R7: Written values of bits 1, 3, 4, 5, 6 and 7 are ignored. Writing 8'hFF reads back as 8'h05 plus the live interrupt flags.
- R8: A written selection does not reach ch_en, or the read-back, until the next STOP. Only that STOP applies it.
- R9: A START, which is SDA falling while SCL is high, begins a new address phase from any state, including straight after a rejected address. A STOP, which is SDA rising while SCL is high, returns the bus logic to idle.
- R10: Every data byte written to the block is acknowledged. The block begins driving SDA only after a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled level of the upstream SCL line |
| sda_in | input | 1 | Sampled level of the upstream SDA line |
| sda_oe | output | 1 | High to pull the upstream SDA line low |
| strap | input | 3 | Address strap inputs, low three address bits |
| irq0_n | input | 1 | Active-low interrupt from channel 0 |
| irq1_n | input | 1 | Active-low interrupt from channel 1 |
| irq_out_n | output | 1 | Active-low combined interrupt |
| ch_en | output | 2 | Channel enables, bit 0 for channel 0, bit 1 for channel 1 |

## Verification
Four properties are checked on every cycle:
- the two channel enables stay exclusive;
- the combined interrupt follows both inputs;
- the enables change only in the cycle after a detected STOP;
- the SDA pull-down starts only after a falling SCL edge.

Other behaviours depend on whole bus transactions, and only the bench scenarios can show them:
- which addresses are accepted;
- how each control byte decodes;
- that read-only and unused bits are masked;
- that a written value stays pending until STOP, including across a repeated START read;
- that a reset in the middle of operation clears the selection.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int STRAP_W = 3;
  localparam logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b1110;
  localparam int EN_BIT = 2;
  localparam int SEL_BIT = 0;
  localparam int IRQ0_BIT = 4;
  localparam int IRQ1_BIT = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_WR, ST_ACK_W, ST_RD, ST_RACK
  } phase_t;

  // address comparison: fixed upper nibble followed by the straps
  function automatic logic addr_hit(logic [ADDR_W-1:0] rx, logic [STRAP_W-1:0] strap);
    return rx == {ADDR_HI, strap};
  endfunction

  // one-hot-or-zero channel enable decode
  function automatic logic [1:0] chan_decode(logic en, logic sel);
    if (!en) return 2'b00;
    return sel ? 2'b10 : 2'b01;
  endfunction

  // byte presented on a read
  function automatic logic [BYTE_W-1:0] status_byte(logic en, logic sel, logic irq0_n, logic irq1_n);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[EN_BIT] = en;
    b[SEL_BIT] = sel;
    b[IRQ0_BIT] = ~irq0_n;
    b[IRQ1_BIT] = ~irq1_n;
    return b;
  endfunction
endpackage

// File: rtl/chsel_line_sync.sv
module chsel_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/chsel_target.sv
module chsel_target
  import chsel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_evt,
  input  logic                stop_evt,
  input  logic [STRAP_W-1:0]  strap,
  input  logic [BYTE_W-1:0]   rd_byte,
  output logic                sda_oe,
  output logic                wr_stb,
  output logic [1:0]          wr_ctl
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_t              phase;
  logic [CNT_W-1:0]    cnt;
  logic [BYTE_W-1:0]   shreg, tx;
  logic                rnw, mack;

  assign wr_ctl = {shreg[EN_BIT], shreg[SEL_BIT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      tx     <= '0;
      rnw    <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        phase  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        phase  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (phase == ST_ADDR) begin
                if (addr_hit(shreg[BYTE_W-1:1], strap)) begin
                  rnw    <= shreg[0];
                  sda_oe <= 1'b1;
                  phase  <= ST_ACK_A;
                end else begin
                  phase <= ST_IDLE;
                end
              end else begin
                wr_stb <= 1'b1;
                sda_oe <= 1'b1;
                phase  <= ST_ACK_W;
              end
            end
          end
          ST_ACK_A: if (scl_fall) begin
            cnt <= '0;
            if (rnw) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[BYTE_W-1];
              phase  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              phase  <= ST_WR;
            end
          end
          ST_ACK_W: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            phase  <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                phase  <= ST_RACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                cnt    <= '0;
                phase  <= ST_RD;
              end else begin
                phase <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/chsel_ctrl_reg.sv
module chsel_ctrl_reg
  import chsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [1:0]        wr_ctl,
  input  logic              stop_evt,
  input  logic              irq0_n,
  input  logic              irq1_n,
  output logic [1:0]        ch_en,
  output logic [BYTE_W-1:0] rd_byte
);
  logic pend_vld, pend_en, pend_sel, cur_en, cur_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_en  <= 1'b0;
      pend_sel <= 1'b0;
      cur_en   <= 1'b0;
      cur_sel  <= 1'b0;
    end else begin
      if (wr_stb) begin
        pend_en  <= wr_ctl[1];
        pend_sel <= wr_ctl[0];
        pend_vld <= 1'b1;
      end
      if (stop_evt && pend_vld) begin
        cur_en   <= pend_en;
        cur_sel  <= pend_sel;
        pend_vld <= 1'b0;
      end
    end
  end

  assign ch_en   = chan_decode(cur_en, cur_sel);
  assign rd_byte = status_byte(cur_en, cur_sel, irq0_n, irq1_n);
endmodule

// File: rtl/twin_chan_switch.sv
module twin_chan_switch
  import chsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic               irq0_n,
  input  logic               irq1_n,
  output logic               irq_out_n,
  output logic [1:0]         ch_en
);
  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_stb;
  logic [1:0]        wr_ctl;
  logic [BYTE_W-1:0] rd_byte;

  chsel_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  chsel_target tgt_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .strap(strap), .rd_byte(rd_byte), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_ctl(wr_ctl)
  );

  chsel_ctrl_reg reg_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_ctl(wr_ctl),
    .stop_evt(stop_evt), .irq0_n(irq0_n), .irq1_n(irq1_n),
    .ch_en(ch_en), .rd_byte(rd_byte)
  );

  assign irq_out_n = irq0_n & irq1_n;
endmodule

// File: rtl/twin_chan_switch_chk.sv
module twin_chan_switch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       irq0_n,
  input logic       irq1_n,
  input logic       irq_out_n,
  input logic [1:0] ch_en,
  input logic       scl_fall,
  input logic       stop_evt
);
  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_en[0] && ch_en[1]));

  assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq0_n || !irq1_n) |-> !irq_out_n);

  assert_irq_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0_n && irq1_n) |-> irq_out_n);

  assert_sel_at_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_en) |-> $past(stop_evt));

  assert_drive_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      assert_reset_R4: assert (ch_en == 2'b00 && !sda_oe);
    end
  end
endmodule

bind twin_chan_switch twin_chan_switch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .irq0_n(irq0_n),
  .irq1_n(irq1_n), .irq_out_n(irq_out_n), .ch_en(ch_en),
  .scl_fall(scl_fall), .stop_evt(stop_evt)
);

// File: tb/twin_chan_switch_tb_top.sv
module twin_chan_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] MY_ADDR = {4'b1110, STRAP};

  typedef struct packed {
    logic [6:0] addr;
    logic [7:0] data;
    logic       i0;
    logic       i1;
    logic       ack;
    logic [1:0] en;
    logic [7:0] rb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{7'h75, 8'h04, 1'b1, 1'b1, 1'b1, 2'b01, 8'h04},
    '{7'h75, 8'h05, 1'b0, 1'b1, 1'b1, 2'b10, 8'h15},
    '{7'h75, 8'hFF, 1'b1, 1'b0, 1'b1, 2'b10, 8'h25},
    '{7'h75, 8'h01, 1'b0, 1'b0, 1'b1, 2'b00, 8'h31},
    '{7'h74, 8'h04, 1'b1, 1'b1, 1'b0, 2'b00, 8'h01},
    '{7'h75, 8'h06, 1'b1, 1'b1, 1'b1, 2'b01, 8'h04},
    '{7'h65, 8'h05, 1'b1, 1'b0, 1'b0, 2'b01, 8'h24},
    '{7'h75, 8'h00, 1'b1, 1'b1, 1'b1, 2'b00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic irq0_n = 1'b1;
  logic irq1_n = 1'b1;
  logic sda_oe, irq_out_n;
  logic [1:0] ch_en;
  wire  sda_line = m_sda & ~sda_oe;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_chan_switch dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .strap(STRAP), .irq0_n(irq0_n), .irq1_n(irq1_n),
    .irq_out_n(irq_out_n), .ch_en(ch_en)
  );

  task automatic wq(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = d[i]; wq();
      m_scl = 1'b1; wq(2);
      m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    ack = ~sda_line; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq();
      m_scl = 1'b1; wq();
      b = {b[6:0], sda_line}; wq();
      m_scl = 1'b0; wq();
    end
    m_sda = ~give_ack; wq();
    m_scl = 1'b1; wq(2);
    m_scl = 1'b0; wq();
  endtask

  task automatic write_ctl(input logic [6:0] a, input logic [7:0] d, output logic ack);
    logic ack2;
    bus_start();
    send_byte({a, 1'b0}, ack);
    if (ack) begin
      send_byte(d, ack2);
      chk("R10 data byte ack", 32'(ack2), 32'd1);
    end
    bus_stop();
    repeat (6) @(negedge clk);
  endtask

  task automatic read_ctl(output logic [7:0] b);
    logic ack;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk("R1 read address ack", 32'(ack), 32'd1);
    recv_byte(1'b0, b);
    bus_stop();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b, b2;
    repeat (5) @(negedge clk);
    chk("R4 ch_en in reset", 32'(ch_en), 32'd0);
    chk("R4 sda released in reset", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 ch_en after reset", 32'(ch_en), 32'd0);
    read_ctl(b);
    chk("R4 readback after reset", 32'(b), 32'h00);

    // table walk: R1 R2 R3 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      irq0_n = VECS[v].i0;
      irq1_n = VECS[v].i1;
      repeat (2) @(negedge clk);
      chk($sformatf("R5 vec%0d irq_out_n", v), 32'(irq_out_n), 32'(VECS[v].i0 & VECS[v].i1));
      write_ctl(VECS[v].addr, VECS[v].data, ack);
      chk($sformatf("R1 vec%0d address ack", v), 32'(ack), 32'(VECS[v].ack));
      chk($sformatf("R2 vec%0d ch_en", v), 32'(ch_en), 32'(VECS[v].en));
      chk($sformatf("R3 vec%0d exclusive", v), 32'(ch_en[0] & ch_en[1]), 32'd0);
      read_ctl(b);
      chk($sformatf("R6 R7 vec%0d readback", v), 32'(b), 32'(VECS[v].rb));
    end

    // R8: selection held until STOP, repeated START read shows old value
    irq0_n = 1'b1; irq1_n = 1'b1;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    send_byte(8'h05, ack);
    repeat (6) @(negedge clk);
    chk("R8 ch_en before STOP", 32'(ch_en), 32'd0);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk("R9 repeated start ack", 32'(ack), 32'd1);
    recv_byte(1'b0, b);
    chk("R8 readback before STOP", 32'(b), 32'h00);
    bus_stop();
    repeat (6) @(negedge clk);
    chk("R8 ch_en after STOP", 32'(ch_en), 32'b10);

    // R6: multi-byte read, live flags per byte
    irq0_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    recv_byte(1'b1, b);
    recv_byte(1'b0, b2);
    bus_stop();
    repeat (6) @(negedge clk);
    chk("R6 multi-read byte0", 32'(b), 32'h15);
    chk("R6 multi-read byte1", 32'(b2), 32'h15);
    irq0_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 irq_out_n released", 32'(irq_out_n), 32'd1);

    // R9: rejected address then repeated START to this block
    bus_start();
    send_byte(8'hE0, ack);
    chk("R1 foreign address nack", 32'(ack), 32'd0);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    chk("R9 restart after nack", 32'(ack), 32'd1);
    send_byte(8'h04, ack);
    bus_stop();
    repeat (6) @(negedge clk);
    chk("R9 ch_en after restart write", 32'(ch_en), 32'b01);

    // R4: reset in mid operation
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 ch_en cleared by reset", 32'(ch_en), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_ctl(b);
    chk("R4 readback after mid reset", 32'(b), 32'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule